// File: doc/BRIEF.md
# JTAG Cable Command Parser

This block sits behind a byte-stream transport, for example a socket payload delivered one byte at a time over a valid/ready pair. It recognises three ASCII command headers: an information query, a clock-period setting and a scan-vector shift. After each header it reads the little-endian binary fields that follow. It answers on a valid/ready byte output.

A shift command carries a bit count, a TMS vector and a TDI vector. The block writes both vectors into the buffers of an external scan engine through byte-wide write strobes, then starts the engine with a one-cycle pulse. When the engine reports completion, the block reads the captured TDO bytes back through the same buffer address and returns them as the reply.

Only one command is in progress at a time. Input is held off while the engine runs and while a reply is being sent. A malformed header, or a shift longer than the advertised maximum, puts the block into a silent error state. In that state it swallows all further input until reset.

Top module: `jtag_cmd_parser`

## Requirements
- R1: The headers `getinfo:`, `settck:` and `shift:` are matched byte by byte. As soon as a received byte cannot continue any of the three, `errFlag` rises and stays high until reset. From then on `inReady` stays high, every byte is discarded and `outValid` never rises.
- R2: After `getinfo:` the reply is the ASCII text `xvcServer_v1.0:`, then `MAX_BITS` written in decimal, then one byte 0x0A.
- R3: After `settck:` four bytes form the requested period, least significant byte first. A value in the range `PERIOD_MIN..PERIOD_MAX` replaces `tckPeriod`; any other value leaves it unchanged. The reply is the period in force afterwards, as four bytes, least significant first.
- R4: After `shift:` four bytes, least significant first, give the bit count n. Then ceil(n/8) TMS bytes are written with `tmsWe` at `bufAddr` 0, 1, 2 and so on, followed by ceil(n/8) TDI bytes written the same way with `tdiWe`. Then `shiftStart` pulses for one cycle with `shiftBits` = n.
- R5: From the `shiftStart` pulse until `shiftDone` is seen, `inReady` is low. The reply is then ceil(n/8) bytes, byte k being `tdoData` while `bufAddr` = k.
- R6: A shift whose bit count exceeds `MAX_BITS` enters the error state of R1 right after its fourth count byte. No vector is written and the engine is not started.
- R7: While a reply is pending, `inReady` is low. A reply byte held back by a low `outReady` keeps `outValid` high and `outData` unchanged.
- R8: After reset: `inReady` = 1, `outValid` = 0, `errFlag` = 0, `shiftStart` = 0 and `tckPeriod` = `PERIOD_RESET`.
- R9: A shift with a bit count of 0 writes no vector bytes. It still pulses `shiftStart` with `shiftBits` = 0, sends no reply bytes, and then accepts the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Command stream byte |
| inValid | input | 1 | inData is valid |
| inReady | output | 1 | Parser accepts inData this cycle |
| outData | output | 8 | Reply byte |
| outValid | output | 1 | outData is valid |
| outReady | input | 1 | Consumer accepts outData this cycle |
| tmsWe | output | 1 | Write strobe for the TMS vector buffer |
| tdiWe | output | 1 | Write strobe for the TDI vector buffer |
| bufAddr | output | AW | Byte address for vector writes and TDO reads |
| vecData | output | 8 | Byte written to the vector buffers |
| shiftBits | output | 32 | Bit count of the current shift |
| shiftStart | output | 1 | One-cycle engine start pulse |
| shiftDone | input | 1 | Engine has finished the shift |
| tdoData | input | 8 | Captured TDO byte at bufAddr |
| tckPeriod | output | 32 | Scan clock period in force, in ns |
| errFlag | output | 1 | Sticky protocol error |

## Verification
A table of commands runs back to back. It covers accepted and refused period values, which separates applying a period from merely echoing it. Shift lengths of 1, 13 and 64 bits probe the rounding to whole bytes and the end of the buffer, where a wrong address or an off-by-one byte count shows up in the TDO echo. Directed cases then hold the reply under backpressure, send a zero-length shift, send a count one above the maximum, and send a header that diverges after two matching characters. These show whether the error path stays silent and keeps swallowing input.

// File: rtl/jcp_pkg.sv
package jcp_pkg;

  typedef enum logic [1:0] {CMD_INFO = 2'd0, CMD_TCK = 2'd1, CMD_SHIFT = 2'd2} cmd_e;

  typedef enum logic [2:0] {
    S_HEADER, S_FIELD, S_TMS, S_TDI, S_START, S_WAIT, S_REPLY, S_ERROR
  } state_e;

  typedef struct packed {
    logic idxClr;
    logic idxInc;
    logic candReset;
    logic candStep;
    logic cmdLatch;
    logic fieldShift;
    logic tckApply;
    logic bitsLatch;
  } strobe_t;

  localparam int NCMD = 3;
  localparam logic [63:0]  HDR_INFO  = "getinfo:";
  localparam logic [63:0]  HDR_TCK   = "settck:";
  localparam logic [63:0]  HDR_SHIFT = "shift:";
  localparam logic [119:0] INFO_HEAD = "xvcServer_v1.0:";
  localparam int INFO_HEAD_LEN = 15;

  function automatic int hdrLen(int c);
    return (c == 0) ? 8 : (c == 1) ? 7 : 6;
  endfunction

  function automatic logic [7:0] hdrChar(int c, logic [4:0] i);
    logic [63:0] p;
    int l;
    p = (c == 0) ? HDR_INFO : (c == 1) ? HDR_TCK : HDR_SHIFT;
    l = hdrLen(c);
    if (int'(i) >= l) return 8'h00;
    return p[8*(l-1-int'(i)) +: 8];
  endfunction

  function automatic int decDigits(int unsigned v);
    int n = 1;
    for (int k = 0; k < 9; k++)
      if (v >= 10) begin
        v = v / 10;
        n++;
      end
    return n;
  endfunction

  // Info reply, byte i at bits [8*i +: 8]
  function automatic logic [255:0] buildInfo(int unsigned maxBits);
    logic [255:0] v = '0;
    int nd = decDigits(maxBits);
    int unsigned t = maxBits;
    for (int i = 0; i < INFO_HEAD_LEN; i++)
      v[8*i +: 8] = INFO_HEAD[8*(INFO_HEAD_LEN-1-i) +: 8];
    for (int k = 0; k < 10; k++)
      if (k < nd) begin
        v[8*(INFO_HEAD_LEN+nd-1-k) +: 8] = 8'(8'h30 + t % 10);
        t = t / 10;
      end
    v[8*(INFO_HEAD_LEN+nd) +: 8] = 8'h0A;
    return v;
  endfunction

endpackage

// File: rtl/jcp_datapath.sv
module jcp_datapath
  import jcp_pkg::*;
#(
  parameter int unsigned MAX_BITS     = 64,
  parameter int unsigned PERIOD_MIN   = 10,
  parameter int unsigned PERIOD_MAX   = 100000,
  parameter int unsigned PERIOD_RESET = 100,
  parameter int          AW           = 3,
  parameter int          IDXW         = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [7:0]      inData,
  input  logic [7:0]      tdoData,
  output cmd_e            cmd,
  output cmd_e            hitCmd,
  output logic            hdrHit,
  output logic            hdrMiss,
  output logic            fieldDone,
  output logic            bitsTooBig,
  output logic            bitsZero,
  output logic            vecDone,
  output logic            replyDone,
  output logic [7:0]      outData,
  output logic [31:0]     numBits,
  output logic [31:0]     tckPeriod,
  output logic [AW-1:0]   bufAddr
);

  localparam int unsigned INFO_LEN = 32'(INFO_HEAD_LEN + decDigits(MAX_BITS) + 1);
  localparam logic [255:0] INFO_VEC = buildInfo(MAX_BITS);

  logic [IDXW-1:0] idx;
  logic [NCMD-1:0] cand, candNext, endsHere;
  logic [31:0]     field, fieldNext, nBytes, replyLen;

  for (genvar c = 0; c < NCMD; c++) begin : g_hdr
    assign candNext[c] = cand[c] && (inData == hdrChar(c, idx[4:0]));
    assign endsHere[c] = candNext[c] && (32'(idx) == 32'(hdrLen(c) - 1));
  end

  assign hdrHit  = |endsHere;
  assign hdrMiss = (candNext == '0);
  assign hitCmd  = endsHere[2] ? CMD_SHIFT : endsHere[1] ? CMD_TCK : CMD_INFO;

  assign fieldNext  = {inData, field[31:8]};
  assign fieldDone  = (idx == IDXW'(3));
  assign bitsTooBig = (fieldNext > MAX_BITS);
  assign bitsZero   = (fieldNext == '0);

  assign nBytes  = (numBits + 32'd7) >> 3;
  assign vecDone = (32'(idx) + 32'd1 == nBytes);

  always_comb begin
    case (cmd)
      CMD_INFO: replyLen = INFO_LEN;
      CMD_TCK:  replyLen = 32'd4;
      default:  replyLen = nBytes;
    endcase
  end
  assign replyDone = (32'(idx) == replyLen);

  always_comb begin
    case (cmd)
      CMD_INFO: outData = INFO_VEC[{idx[4:0], 3'b000} +: 8];
      CMD_TCK:  outData = tckPeriod[{idx[1:0], 3'b000} +: 8];
      default:  outData = tdoData;
    endcase
  end

  assign bufAddr = idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx       <= '0;
      cand      <= '1;
      cmd       <= CMD_INFO;
      field     <= '0;
      numBits   <= '0;
      tckPeriod <= PERIOD_RESET;
    end else begin
      if (stb.idxClr)      idx <= '0;
      else if (stb.idxInc) idx <= idx + 1'b1;
      if (stb.candReset)     cand <= '1;
      else if (stb.candStep) cand <= candNext;
      if (stb.cmdLatch)   cmd <= hitCmd;
      if (stb.fieldShift) field <= fieldNext;
      if (stb.bitsLatch)  numBits <= fieldNext;
      if (stb.tckApply && fieldNext >= PERIOD_MIN && fieldNext <= PERIOD_MAX)
        tckPeriod <= fieldNext;
    end
  end

endmodule

// File: rtl/jcp_ctrl.sv
module jcp_ctrl
  import jcp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    outReady,
  input  logic    shiftDone,
  input  cmd_e    cmd,
  input  cmd_e    hitCmd,
  input  logic    hdrHit,
  input  logic    hdrMiss,
  input  logic    fieldDone,
  input  logic    bitsTooBig,
  input  logic    bitsZero,
  input  logic    vecDone,
  input  logic    replyDone,
  output strobe_t stb,
  output logic    inReady,
  output logic    outValid,
  output logic    tmsWe,
  output logic    tdiWe,
  output logic    shiftStart,
  output logic    errFlag
);

  state_e state, stateNext;

  always_comb begin
    stateNext  = state;
    stb        = '0;
    inReady    = 1'b0;
    outValid   = 1'b0;
    tmsWe      = 1'b0;
    tdiWe      = 1'b0;
    shiftStart = 1'b0;
    case (state)
      S_HEADER: begin
        inReady = 1'b1;
        if (inValid) begin
          if (hdrMiss) stateNext = S_ERROR;
          else if (hdrHit) begin
            stb.cmdLatch = 1'b1;
            stb.idxClr   = 1'b1;
            stateNext    = (hitCmd == CMD_INFO) ? S_REPLY : S_FIELD;
          end else begin
            stb.idxInc   = 1'b1;
            stb.candStep = 1'b1;
          end
        end
      end
      S_FIELD: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.fieldShift = 1'b1;
          if (!fieldDone) stb.idxInc = 1'b1;
          else begin
            stb.idxClr = 1'b1;
            if (cmd == CMD_TCK) begin
              stb.tckApply = 1'b1;
              stateNext    = S_REPLY;
            end else if (bitsTooBig) stateNext = S_ERROR;
            else begin
              stb.bitsLatch = 1'b1;
              stateNext     = bitsZero ? S_START : S_TMS;
            end
          end
        end
      end
      S_TMS, S_TDI: begin
        inReady = 1'b1;
        if (inValid) begin
          tmsWe = (state == S_TMS);
          tdiWe = (state == S_TDI);
          if (vecDone) begin
            stb.idxClr = 1'b1;
            stateNext  = (state == S_TMS) ? S_TDI : S_START;
          end else stb.idxInc = 1'b1;
        end
      end
      S_START: begin
        shiftStart = 1'b1;
        stateNext  = S_WAIT;
      end
      S_WAIT: begin
        if (shiftDone) begin
          stb.idxClr = 1'b1;
          stateNext  = S_REPLY;
        end
      end
      S_REPLY: begin
        if (replyDone) begin
          stb.idxClr    = 1'b1;
          stb.candReset = 1'b1;
          stateNext     = S_HEADER;
        end else begin
          outValid = 1'b1;
          if (outReady) stb.idxInc = 1'b1;
        end
      end
      default: inReady = 1'b1;
    endcase
  end

  assign errFlag = (state == S_ERROR);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_HEADER;
    else       state <= stateNext;
  end

endmodule

// File: rtl/jtag_cmd_parser.sv
module jtag_cmd_parser
  import jcp_pkg::*;
#(
  parameter int unsigned MAX_BITS     = 64,
  parameter int unsigned PERIOD_MIN   = 10,
  parameter int unsigned PERIOD_MAX   = 100000,
  parameter int unsigned PERIOD_RESET = 100,
  localparam int MAX_BYTES = (MAX_BITS + 7) / 8,
  localparam int AW        = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int IDXW      = ((AW > 5) ? AW : 5) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    inData,
  input  logic          inValid,
  output logic          inReady,
  output logic [7:0]    outData,
  output logic          outValid,
  input  logic          outReady,
  output logic          tmsWe,
  output logic          tdiWe,
  output logic [AW-1:0] bufAddr,
  output logic [7:0]    vecData,
  output logic [31:0]   shiftBits,
  output logic          shiftStart,
  input  logic          shiftDone,
  input  logic [7:0]    tdoData,
  output logic [31:0]   tckPeriod,
  output logic          errFlag
);

  strobe_t stb;
  cmd_e    cmd, hitCmd;
  logic    hdrHit, hdrMiss, fieldDone, bitsTooBig, bitsZero, vecDone, replyDone;

  assign vecData = inData;

  jcp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .shiftDone(shiftDone), .cmd(cmd), .hitCmd(hitCmd), .hdrHit(hdrHit),
    .hdrMiss(hdrMiss), .fieldDone(fieldDone), .bitsTooBig(bitsTooBig),
    .bitsZero(bitsZero), .vecDone(vecDone), .replyDone(replyDone),
    .stb(stb), .inReady(inReady), .outValid(outValid), .tmsWe(tmsWe),
    .tdiWe(tdiWe), .shiftStart(shiftStart), .errFlag(errFlag)
  );

  jcp_datapath #(
    .MAX_BITS(MAX_BITS), .PERIOD_MIN(PERIOD_MIN), .PERIOD_MAX(PERIOD_MAX),
    .PERIOD_RESET(PERIOD_RESET), .AW(AW), .IDXW(IDXW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .tdoData(tdoData),
    .cmd(cmd), .hitCmd(hitCmd), .hdrHit(hdrHit), .hdrMiss(hdrMiss),
    .fieldDone(fieldDone), .bitsTooBig(bitsTooBig), .bitsZero(bitsZero),
    .vecDone(vecDone), .replyDone(replyDone), .outData(outData),
    .numBits(shiftBits), .tckPeriod(tckPeriod), .bufAddr(bufAddr)
  );

endmodule

// File: rtl/jcp_checker.sv
module jcp_checker #(
  parameter int unsigned PERIOD_MIN = 10,
  parameter int unsigned PERIOD_MAX = 100000
) (
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [7:0]  outData,
  input logic        shiftStart,
  input logic        errFlag,
  input logic [31:0] tckPeriod,
  input logic        tmsWe,
  input logic        tdiWe
);

  assert_err_sticky_R1: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  assert_err_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!outValid && inReady));

  assert_period_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tckPeriod) |-> (tckPeriod >= PERIOD_MIN && tckPeriod <= PERIOD_MAX));

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    shiftStart |=> !shiftStart);

  assert_we_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(tmsWe && tdiWe));

  assert_start_blocks_input_R5: assert property (@(posedge clk) disable iff (!rstN)
    shiftStart |=> !inReady);

  assert_no_accept_in_reply_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

bind jtag_cmd_parser jcp_checker #(.PERIOD_MIN(PERIOD_MIN), .PERIOD_MAX(PERIOD_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .shiftStart(shiftStart),
  .errFlag(errFlag), .tckPeriod(tckPeriod), .tmsWe(tmsWe), .tdiWe(tdiWe)
);

// File: tb/jtag_cmd_parser_tb.sv
`timescale 1ns/1ps
module jtag_cmd_parser_tb;

  localparam int unsigned MAXB  = 64;
  localparam int unsigned PMIN  = 10;
  localparam int unsigned PMAX  = 100000;
  localparam int unsigned PRST  = 100;
  localparam int          NBUF  = (MAXB + 7) / 8;
  localparam int          AW    = $clog2(NBUF);

  // kind: 0 info, 1 period, 2 shift ; value ; expected period echo (kind 1)
  localparam int TBL_N = 8;
  localparam int unsigned tblKind[TBL_N] = '{1, 1, 2, 0, 2, 1, 2, 1};
  localparam int unsigned tblVal [TBL_N] = '{50, 5, 13, 0, 64, 2000000, 1, 100000};
  localparam int unsigned tblExp [TBL_N] = '{50, 50, 0, 0, 0, 50, 0, 100000};

  logic clk = 0, rstN = 0;
  logic [7:0] inData = 0;
  logic inValid = 0, outReady = 1, shiftDone = 0;
  logic inReady, outValid, tmsWe, tdiWe, shiftStart, errFlag;
  logic [7:0] outData, vecData, tdoData;
  logic [AW-1:0] bufAddr;
  logic [31:0] shiftBits, tckPeriod;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] tmsMem [NBUF];
  logic [7:0] tdiMem [NBUF];
  int startCount = 0, busyLeak = 0;
  logic [31:0] lastBits = 0;
  bit busy = 0;

  always #2 clk = ~clk;

  jtag_cmd_parser #(.MAX_BITS(MAXB), .PERIOD_MIN(PMIN), .PERIOD_MAX(PMAX),
    .PERIOD_RESET(PRST)) u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .tmsWe(tmsWe), .tdiWe(tdiWe), .bufAddr(bufAddr),
    .vecData(vecData), .shiftBits(shiftBits), .shiftStart(shiftStart),
    .shiftDone(shiftDone), .tdoData(tdoData), .tckPeriod(tckPeriod),
    .errFlag(errFlag)
  );

  // scan engine model
  always @(posedge clk) begin
    if (tmsWe) tmsMem[bufAddr] <= vecData;
    if (tdiWe) tdiMem[bufAddr] <= vecData;
  end
  assign tdoData = tmsMem[bufAddr] ^ tdiMem[bufAddr] ^ 8'hA5;

  initial forever begin
    @(negedge clk);
    if (shiftStart) begin
      busy = 1;
      startCount++;
      lastBits = shiftBits;
      repeat (6) @(negedge clk);
      shiftDone = 1;
      @(negedge clk);
      shiftDone = 0;
      busy = 0;
    end
  end

  always @(negedge clk) if (busy && inReady) busyLeak++;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sendByte(logic [7:0] b);
    inData = b;
    inValid = 1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic sendStr(string s);
    for (int i = 0; i < s.len(); i++) sendByte(s[i]);
  endtask

  task automatic sendWord(logic [31:0] w);
    for (int i = 0; i < 4; i++) sendByte(w[8*i +: 8]);
  endtask

  task automatic recvByte(output logic [7:0] b);
    while (!outValid) @(negedge clk);
    b = outData;
    @(negedge clk);
  endtask

  task automatic idleCheck(string req);
    repeat (3) @(negedge clk);
    check(!outValid && inReady, req, "idle after command", {outValid, inReady}, 1);
  endtask

  task automatic doInfo();
    string s;
    logic [7:0] b;
    bit ok = 1;
    s = $sformatf("xvcServer_v1.0:%0d\n", MAXB);
    sendStr("getinfo:");
    for (int i = 0; i < s.len(); i++) begin
      recvByte(b);
      if (b != s[i]) begin
        ok = 0;
        check(0, "R2", "info byte", b, s[i]);
      end
    end
    check(ok, "R2", "info text", 0, 0);
    idleCheck("R2");
  endtask

  task automatic doTck(logic [31:0] v, logic [31:0] exp);
    logic [31:0] w;
    logic [7:0] b;
    sendStr("settck:");
    sendWord(v);
    for (int i = 0; i < 4; i++) begin
      recvByte(b);
      w[8*i +: 8] = b;
    end
    check(w == exp, "R3", "period echo", w, exp);
    check(tckPeriod == exp, "R3", "period port", tckPeriod, exp);
    idleCheck("R3");
  endtask

  task automatic doShift(int unsigned n, logic [7:0] seed);
    int nb;
    int s0;
    logic [7:0] t [NBUF];
    logic [7:0] d [NBUF];
    logic [7:0] b;
    nb = (n + 7) / 8;
    s0 = startCount;
    for (int i = 0; i < nb; i++) begin
      t[i] = 8'(seed + i * 37);
      d[i] = 8'(~seed ^ (i * 11));
    end
    sendStr("shift:");
    sendWord(n);
    for (int i = 0; i < nb; i++) sendByte(t[i]);
    for (int i = 0; i < nb; i++) sendByte(d[i]);
    for (int i = 0; i < nb; i++) begin
      recvByte(b);
      check(b == (t[i] ^ d[i] ^ 8'hA5), "R5", "tdo reply byte", b, t[i] ^ d[i] ^ 8'hA5);
      check(tmsMem[i] == t[i] && tdiMem[i] == d[i], "R4", "vector buffer byte",
            {tmsMem[i], tdiMem[i]}, {t[i], d[i]});
    end
    check(startCount == s0 + 1, "R4", "one start pulse", startCount, s0 + 1);
    check(lastBits == n, "R4", "shiftBits", lastBits, n);
    check(busyLeak == 0, "R5", "input blocked while engine busy", busyLeak, 0);
    idleCheck("R5");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    inValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", "run timed out", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] b, held;
    int s0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state
    check(inReady == 1, "R8", "inReady", inReady, 1);
    check(outValid == 0, "R8", "outValid", outValid, 0);
    check(errFlag == 0, "R8", "errFlag", errFlag, 0);
    check(shiftStart == 0, "R8", "shiftStart", shiftStart, 0);
    check(tckPeriod == PRST, "R8", "tckPeriod", tckPeriod, PRST);

    for (int k = 0; k < TBL_N; k++) begin
      case (tblKind[k])
        0: doInfo();
        1: doTck(tblVal[k], tblExp[k]);
        default: doShift(tblVal[k], 8'(k * 29 + 3));
      endcase
    end

    // R7 backpressure on a reply
    sendStr("settck:");
    sendWord(32'd77);
    outReady = 0;
    while (!outValid) @(negedge clk);
    held = outData;
    repeat (5) @(negedge clk);
    check(outValid && outData == held, "R7", "stalled byte held", outData, held);
    check(!inReady, "R7", "input blocked during reply", inReady, 0);
    outReady = 1;
    recvByte(b);
    check(b == 8'd77, "R7", "first byte after stall", b, 77);
    for (int i = 1; i < 4; i++) recvByte(b);
    idleCheck("R7");

    // R9 zero-length shift
    s0 = startCount;
    sendStr("shift:");
    sendWord(32'd0);
    repeat (12) begin
      @(negedge clk);
      if (outValid) check(0, "R9", "unexpected reply byte", 1, 0);
    end
    check(startCount == s0 + 1 && lastBits == 0, "R9", "engine started with 0 bits",
          lastBits, 0);
    check(inReady && !errFlag, "R9", "ready for next command", inReady, 1);
    doInfo();

    // R6 oversized shift
    s0 = startCount;
    sendStr("shift:");
    sendWord(MAXB + 1);
    @(negedge clk);
    check(errFlag == 1, "R6", "error on oversize", errFlag, 1);
    for (int i = 0; i < 6; i++) sendByte(8'(i));
    check(!outValid && inReady, "R6", "silent drain", {outValid, inReady}, 1);
    check(startCount == s0, "R6", "engine not started", startCount, s0);
    doReset();
    check(!errFlag && tckPeriod == PRST, "R8", "reset clears error and period",
          errFlag, 0);

    // R1 bad header diverging after two matching bytes
    sendStr("sexy:");
    check(errFlag == 1, "R1", "error on bad header", errFlag, 1);
    sendStr("getinfo:");
    repeat (10) @(negedge clk);
    check(!outValid && inReady && errFlag, "R1", "swallowed after error",
          {outValid, inReady, errFlag}, 3'b011);
    doReset();
    doTck(32'd10, 32'd10);
    summary();
  end

endmodule